// File: doc/BRIEF.md
# USB Endpoint Receive-Buffer Read Port

This block is the processor-side read path for OUT packets held in per-endpoint receive buffers. Each logical endpoint owns one packet buffer. A simple byte write port, driven by the serial side or a testbench, fills the buffer. Software picks a logical endpoint and sets a read-enable bit in a control register. It then drains the packet one 32-bit word at a time through a receive-data register. A packet-length register shows how many bytes of the current packet are still unread, whether the packet was received correctly, and whether a packet is waiting.

A table of 32 maximum-packet-size entries, one per physical endpoint, is addressed through an index register. It caps how many bytes a buffer accepts. Logical endpoint `n` uses the entry of physical endpoint `2n`, which is its OUT direction. When the last bytes of a packet are read, the buffer is freed for the next packet and the read-enable bit clears itself.

Register offsets on `reg_addr`: 0 control, 1 receive data, 2 packet length, 3 endpoint index, 4 maximum packet size. All register reads are registered: `reg_rdata` takes the value one clock edge after the strobe and holds it until the next read.

Top module: `usb_rx_read_port`

## Requirements
- R1: After reset, reads of the control, receive-data and packet-length registers return 0. Every maximum-packet-size entry resets to 8.
- R2: A receive-data read returns 0 and leaves all buffer state unchanged when read-enable (control bit 0) is clear or the selected endpoint holds no ready packet.
- R3: The logical endpoint in control bits [LEP_W:1] (bits 2:1 at default) alone decides which buffer a data read returns and advances.
- R4: Data words are packed little-endian: the first unread byte is in bits 7:0. In a partly filled last word, the bytes beyond the packet end read as 0.
- R5: The packet-length register gives the remaining byte count in bits 9:0, the valid flag in bit 10 and the packet-ready flag in bit 11. Each data read lowers the count by min(4, remaining). The register reads 0 while read-enable is clear.
- R6: A data read that empties the packet (remaining ≤ 4, including a zero-length packet) frees the buffer and clears read-enable. The endpoint then accepts a new packet.
- R7: The endpoint index register (bits 4:0) selects which of 32 ten-bit maximum-packet-size entries the size register reads and writes. Fill bytes beyond min(entry of physical endpoint 2n, buffer size) are discarded.
- R8: Writes to the receive-data and packet-length offsets have no effect.
- R9: Fill bytes and end marks for an endpoint that already holds a ready packet are discarded.
- R10: The valid flag copies `fill_good` at the end mark. A packet marked not valid can still be read in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Registered read data |
| fill_ep | input | LEP_W | Logical endpoint being filled |
| fill_byte_en | input | 1 | A fill byte is presented |
| fill_byte | input | 8 | Fill byte, in bus order |
| fill_end | input | 1 | End-of-packet mark |
| fill_good | input | 1 | Packet-valid flag sampled with the end mark |

## Verification
The hardest situations to reach are those where stimulus collides with a buffer that is still occupied. Examples are a second packet arriving before the first is drained, or software switching endpoints halfway through a packet. The stimulus fills two endpoints, reads part of one, reselects the other and then returns, checking that each countdown is untouched by the other. Gated reads, zero-length packets and truncation by a reprogrammed size entry are reached by writing the control, index and size registers between fills.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  localparam int ADDR_W    = 3;
  localparam int LEN_W     = 10;
  localparam int VALID_BIT = 10;
  localparam int READY_BIT = 11;
  localparam int NUM_PHYS  = 32;
  localparam int IDX_W     = $clog2(NUM_PHYS);

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 3'd0,
    RA_DATA  = 3'd1,
    RA_LEN   = 3'd2,
    RA_EPIDX = 3'd3,
    RA_MPS   = 3'd4
  } reg_addr_e;

  // bytes consumed by one data read
  function automatic logic [2:0] step_bytes(input logic [LEN_W-1:0] rem);
    return (rem >= LEN_W'(4)) ? 3'd4 : rem[2:0];
  endfunction

  // clear the lanes at or beyond the packet end
  function automatic logic [31:0] mask_word(input logic [31:0] raw,
                                            input logic [LEN_W-1:0] rem);
    logic [31:0] res;
    res = '0;
    for (int k = 0; k < 4; k++)
      if (LEN_W'(k) < rem) res[8*k +: 8] = raw[8*k +: 8];
    return res;
  endfunction

  function automatic logic [LEN_W-1:0] clamp_limit(input logic [LEN_W-1:0] mps,
                                                   input int unsigned cap);
    return (mps > LEN_W'(cap)) ? LEN_W'(cap) : mps;
  endfunction
endpackage

// File: rtl/usb_rx_mps_table.sv
module usb_rx_mps_table
  import usb_rx_pkg::*;
#(
  parameter int unsigned MPS_RESET = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  idx_wr,
  input  logic [IDX_W-1:0]                      idx_val,
  input  logic                                  mps_wr,
  input  logic [LEN_W-1:0]                      mps_val,
  output logic [IDX_W-1:0]                      idx,
  output logic [LEN_W-1:0]                      mps_sel,
  output logic [NUM_PHYS-1:0][LEN_W-1:0]        mps_all
);
  always_ff @(posedge clk) begin
    if (!rst_n) idx <= '0;
    else if (idx_wr) idx <= idx_val;
  end

  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_entry
    logic hit;
    assign hit = mps_wr && (idx == IDX_W'(p));
    always_ff @(posedge clk) begin
      if (!rst_n) mps_all[p] <= LEN_W'(MPS_RESET);
      else if (hit) mps_all[p] <= mps_val;
    end
  end

  assign mps_sel = mps_all[idx];

  // R7: a size write lands in the entry the index points at
  a_r7_mps_write: assert property (@(posedge clk) disable iff (!rst_n)
    mps_wr && !idx_wr |=> mps_sel == $past(mps_val));
endmodule

// File: rtl/usb_rx_ep_buffer.sv
module usb_rx_ep_buffer
  import usb_rx_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] limit,
  input  logic             wr_byte_en,
  input  logic [7:0]       wr_byte,
  input  logic             wr_end,
  input  logic             wr_good,
  input  logic             pop,
  output logic [31:0]      word,
  output logic [LEN_W-1:0] rem,
  output logic             ready,
  output logic             valid,
  output logic             release_evt
);
  localparam int CNT_W = $clog2(BUF_BYTES + 1);
  localparam int AW    = $clog2(BUF_BYTES);

  logic [7:0]       mem [BUF_BYTES];
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] rd_ptr;
  logic             accept_byte;
  logic             accept_end;
  logic [31:0]      raw;
  logic [2:0]       step;

  assign accept_byte = wr_byte_en && !ready && (LEN_W'(count) < limit);
  assign accept_end  = wr_end && !ready;
  assign rem         = LEN_W'(count - rd_ptr);
  assign step        = step_bytes(rem);
  assign release_evt = pop && ready && (rem <= LEN_W'(4));

  always_ff @(posedge clk)
    if (accept_byte) mem[count[AW-1:0]] <= wr_byte;

  always_comb begin
    raw = '0;
    for (int k = 0; k < 4; k++) begin
      logic [LEN_W-1:0] at;
      at = LEN_W'(rd_ptr) + LEN_W'(k);
      if (at < LEN_W'(BUF_BYTES)) raw[8*k +: 8] = mem[at[AW-1:0]];
    end
  end
  assign word = mask_word(raw, rem);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      rd_ptr <= '0;
      ready  <= 1'b0;
      valid  <= 1'b0;
    end else if (release_evt) begin
      count  <= '0;
      rd_ptr <= '0;
      ready  <= 1'b0;
      valid  <= 1'b0;
    end else if (pop && ready) begin
      rd_ptr <= rd_ptr + CNT_W'(step);
    end else begin
      if (accept_byte) count <= count + 1'b1;
      if (accept_end) begin
        ready <= 1'b1;
        valid <= wr_good;
      end
    end
  end

  // R5: a read of a long packet lowers the count by exactly four
  a_r5_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    pop && ready && rem > LEN_W'(4) |=> rem == $past(rem) - LEN_W'(4));
  // R6: emptying the packet frees the buffer
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> !ready && rem == '0);
  // R7: no byte lands once the limit is reached
  a_r7_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !ready && LEN_W'(count) >= limit && !wr_end |=> $stable(count));
  // R9: a ready packet is only changed by a read
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !pop |=> ready && $stable(rem) && $stable(valid));
endmodule

// File: rtl/usb_rx_read_port.sv
module usb_rx_read_port
  import usb_rx_pkg::*;
#(
  parameter int unsigned NUM_LEP   = 4,
  parameter int unsigned BUF_BYTES = 64,
  parameter int unsigned MPS_RESET = 8,
  localparam int LEP_W = $clog2(NUM_LEP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  input  logic [LEP_W-1:0]  fill_ep,
  input  logic              fill_byte_en,
  input  logic [7:0]        fill_byte,
  input  logic              fill_end,
  input  logic              fill_good
);
  logic                           ctrl_en;
  logic [LEP_W-1:0]               ctrl_ep;
  logic [IDX_W-1:0]               ep_idx;
  logic [LEN_W-1:0]               mps_sel;
  logic [NUM_PHYS-1:0][LEN_W-1:0] mps_all;

  logic [31:0]      ep_word  [NUM_LEP];
  logic [LEN_W-1:0] ep_rem   [NUM_LEP];
  logic [NUM_LEP-1:0] ep_ready, ep_valid, ep_release;

  logic data_rd, data_fire, any_release;
  logic [31:0] len_view;
  logic wr_ctrl, wr_idx, wr_mps;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_idx  = reg_wr && (reg_addr == RA_EPIDX);
  assign wr_mps  = reg_wr && (reg_addr == RA_MPS);

  usb_rx_mps_table #(.MPS_RESET(MPS_RESET)) u_mps (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_wr  (wr_idx),
    .idx_val (reg_wdata[IDX_W-1:0]),
    .mps_wr  (wr_mps),
    .mps_val (reg_wdata[LEN_W-1:0]),
    .idx     (ep_idx),
    .mps_sel (mps_sel),
    .mps_all (mps_all)
  );

  assign data_rd   = reg_rd && (reg_addr == RA_DATA);
  assign data_fire = data_rd && ctrl_en && ep_ready[ctrl_ep];

  for (genvar e = 0; e < NUM_LEP; e++) begin : g_ep
    logic [LEN_W-1:0] limit;
    logic             sel_fill;
    assign limit    = clamp_limit(mps_all[2*e], BUF_BYTES);
    assign sel_fill = (fill_ep == LEP_W'(e));
    usb_rx_ep_buffer #(.BUF_BYTES(BUF_BYTES)) u_buf (
      .clk         (clk),
      .rst_n       (rst_n),
      .limit       (limit),
      .wr_byte_en  (fill_byte_en && sel_fill),
      .wr_byte     (fill_byte),
      .wr_end      (fill_end && sel_fill),
      .wr_good     (fill_good),
      .pop         (data_fire && (ctrl_ep == LEP_W'(e))),
      .word        (ep_word[e]),
      .rem         (ep_rem[e]),
      .ready       (ep_ready[e]),
      .valid       (ep_valid[e]),
      .release_evt (ep_release[e])
    );
  end

  assign any_release = |ep_release;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      ctrl_ep <= '0;
    end else if (wr_ctrl) begin
      ctrl_en <= reg_wdata[0];
      ctrl_ep <= reg_wdata[LEP_W:1];
    end else if (any_release) begin
      ctrl_en <= 1'b0;
    end
  end

  always_comb begin
    len_view = '0;
    if (ctrl_en) begin
      len_view[LEN_W-1:0] = ep_rem[ctrl_ep];
      len_view[VALID_BIT] = ep_valid[ctrl_ep];
      len_view[READY_BIT] = ep_ready[ctrl_ep];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        RA_CTRL:  reg_rdata <= 32'({ctrl_ep, ctrl_en});
        RA_DATA:  reg_rdata <= data_fire ? ep_word[ctrl_ep] : '0;
        RA_LEN:   reg_rdata <= len_view;
        RA_EPIDX: reg_rdata <= 32'(ep_idx);
        RA_MPS:   reg_rdata <= 32'(mps_sel);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // R2: a gated data read yields zero
  a_r2_gated_zero: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !data_fire |=> reg_rdata == '0);
  // R6: freeing a buffer drops read-enable
  a_r6_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
    any_release && !wr_ctrl |=> !ctrl_en);
  // R3: only the selected endpoint can release
  a_r3_one_release: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ep_release));
  // R8: writes at the read-only offsets leave the enable untouched
  a_r8_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == RA_DATA || reg_addr == RA_LEN) |=> $stable(ctrl_en) && $stable(ctrl_ep));
endmodule

// File: tb/test_usb_rx_read_port.sv
module test_usb_rx_read_port;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 0;
  logic [31:0] reg_rdata;
  logic [1:0]  fill_ep = '0;
  logic        fill_byte_en = 0;
  logic [7:0]  fill_byte = '0;
  logic        fill_end = 0;
  logic        fill_good = 0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  usb_rx_read_port i_usb_rx_read_port (.*);

  localparam logic [2:0] A_CTRL = 0, A_DATA = 1, A_LEN = 2, A_IDX = 3, A_MPS = 4;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic fill(input int ep, input int n, input int seed, input bit good);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fill_ep = 2'(ep); fill_byte_en = 1; fill_byte = 8'(seed + i);
    end
    @(negedge clk); fill_byte_en = 0; fill_ep = 2'(ep); fill_end = 1; fill_good = good;
    @(negedge clk); fill_end = 0;
  endtask

  // little-endian word starting at byte offset, zero past the end
  function automatic logic [31:0] exp_word(input int seed, input int off, input int len);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++)
      if (off + k < len) w[8*k +: 8] = 8'(seed + off + k);
    return w;
  endfunction

  function automatic logic [31:0] exp_len(input bit rdy, input bit vld, input int n);
    return {20'd0, rdy, vld, 10'(n)};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CTRL, d); check("R1 ctrl", d, 0);
    rd(A_DATA, d); check("R1 data", d, 0);
    rd(A_LEN, d);  check("R1 len", d, 0);
    wr(A_IDX, 2);  rd(A_MPS, d); check("R1 mps reset", d, 8);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    fill(1, 7, 8'h10, 1);
    wr(A_CTRL, (1 << 1) | 1);
    rd(A_LEN, d);  check("R5 len start", d, exp_len(1, 1, 7));
    rd(A_DATA, d); check("R4 word0", d, exp_word(8'h10, 0, 7));
    rd(A_LEN, d);  check("R5 len after read", d, exp_len(1, 1, 3));
    rd(A_DATA, d); check("R4 partial word", d, exp_word(8'h10, 4, 7));
    rd(A_LEN, d);  check("R6 len after release", d, 0);
    rd(A_CTRL, d); check("R6 enable cleared", d, 32'h2);
    fill(1, 2, 8'h70, 1);
    wr(A_CTRL, (1 << 1) | 1);
    rd(A_LEN, d);  check("R6 new packet accepted", d, exp_len(1, 1, 2));
    rd(A_DATA, d); check("R6 new packet data", d, exp_word(8'h70, 0, 2));
  endtask

  task automatic t_gating_and_hold();
    logic [31:0] d;
    fill(2, 5, 8'h20, 1);
    wr(A_CTRL, 2 << 1);
    rd(A_DATA, d); check("R2 gated read zero", d, 0);
    rd(A_LEN, d);  check("R5 len zero while disabled", d, 0);
    wr(A_CTRL, (2 << 1) | 1);
    rd(A_LEN, d);  check("R2 state unchanged", d, exp_len(1, 1, 5));
    fill(2, 4, 8'h30, 0);
    rd(A_LEN, d);  check("R9 overfill ignored", d, exp_len(1, 1, 5));
    wr(A_LEN, 32'hFFFF_FFFF);
    wr(A_DATA, 32'hFFFF_FFFF);
    rd(A_LEN, d);  check("R8 ro writes ignored", d, exp_len(1, 1, 5));
    rd(A_CTRL, d); check("R8 ctrl untouched", d, 32'h5);
  endtask

  task automatic t_select();
    logic [31:0] d;
    fill(1, 6, 8'h50, 1);
    wr(A_CTRL, (1 << 1) | 1);
    rd(A_DATA, d); check("R3 ep1 data", d, exp_word(8'h50, 0, 6));
    wr(A_CTRL, (2 << 1) | 1);
    rd(A_DATA, d); check("R9 ep2 kept first packet", d, exp_word(8'h20, 0, 5));
    rd(A_LEN, d);  check("R3 ep2 len", d, exp_len(1, 1, 1));
    rd(A_DATA, d); check("R4 single byte word", d, exp_word(8'h20, 4, 5));
    wr(A_CTRL, (1 << 1) | 1);
    rd(A_LEN, d);  check("R3 ep1 untouched", d, exp_len(1, 1, 2));
    rd(A_DATA, d); check("R3 ep1 tail", d, exp_word(8'h50, 4, 6));
  endtask

  task automatic t_mps();
    logic [31:0] d;
    wr(A_IDX, 6); wr(A_MPS, 12);
    rd(A_MPS, d); check("R7 mps readback", d, 12);
    wr(A_IDX, 7); rd(A_MPS, d); check("R7 neighbour entry", d, 8);
    fill(3, 20, 8'h40, 1);
    wr(A_CTRL, (3 << 1) | 1);
    rd(A_LEN, d); check("R7 truncated to mps", d, exp_len(1, 1, 12));
    for (int w = 0; w < 3; w++) begin
      rd(A_DATA, d); check("R4 mps word", d, exp_word(8'h40, 4 * w, 12));
    end
    rd(A_CTRL, d); check("R6 clear after exact words", d, 32'h6);
    fill(0, 10, 8'h80, 1);
    wr(A_CTRL, 1);
    rd(A_LEN, d); check("R7 default limit", d, exp_len(1, 1, 8));
    rd(A_DATA, d); rd(A_DATA, d); check("R4 default tail", d, exp_word(8'h80, 4, 8));
  endtask

  task automatic t_edges();
    logic [31:0] d;
    fill(0, 0, 0, 1);
    wr(A_CTRL, 1);
    rd(A_LEN, d);  check("R6 zero-length ready", d, exp_len(1, 1, 0));
    rd(A_DATA, d); check("R6 zero-length data", d, 0);
    rd(A_CTRL, d); check("R6 zero-length release", d, 32'h0);
    fill(1, 3, 8'hA0, 0);
    wr(A_CTRL, (1 << 1) | 1);
    rd(A_LEN, d);  check("R10 invalid flag", d, exp_len(1, 0, 3));
    rd(A_DATA, d); check("R10 invalid readable", d, exp_word(8'hA0, 0, 3));
    wr(A_CTRL, (3 << 1) | 1);
    rd(A_DATA, d); check("R2 not-ready read zero", d, 0);
    rd(A_CTRL, d); check("R2 enable kept", d, 32'h7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_gating_and_hold();
    t_select();
    t_mps();
    t_edges();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule